// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for a single synchronous DRAM burst. A one-cycle `start_i` pulse captures a starting column, a three-bit burst length code and a wrap-order select. From the next cycle the block presents one column address per clock on `col_o`, with `valid_o` high. `last_o` marks the final beat of a fixed-length burst.

A fixed burst of N beats keeps the column bits above the low log2(N) bits unchanged. In sequential order the low bits count upward from the start value and wrap within the N-aligned group. In interleaved order the low bits are the start value XORed with the beat index. A full-page burst walks the whole 256-column page, one step per clock, and wraps at the page end. It stops only when `term_i` is asserted. Asserting `term_i` during any beat ends the burst after that beat.

A new `start_i` is accepted in any cycle, including mid-burst and the cycle that shows a final beat. The new burst replaces the old one without a gap.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o` and `last_o` are both 0.
- R2: When `start_i` is sampled high at a clock edge, the following cycle shows `valid_o`=1 and `col_o` equal to the captured start column (beat 0).
- R3: With `wrap_il_i`=0 and a fixed length N, beat k has its low log2(N) bits equal to (start + k) mod N, and all higher bits equal to those of the start column.
- R4: With `wrap_il_i`=1 and a fixed length N, beat k equals the start column with its low log2(N) bits XORed with k.
- R5: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` is 0 in the cycle after the final beat unless a new start was sampled.
- R6: Length codes 4, 5 and 6 give a single-beat burst with `last_o` set on that beat.
- R7: Length code 7 selects full page. The column increments by one per beat modulo 256 from the start column, whatever `wrap_il_i` is. `last_o` is never asserted in this mode.
- R8: If `term_i` is sampled high while a beat is shown and `start_i` is low, `valid_o` is 0 from the next cycle until a new start.
- R9: A `start_i` sampled during the final beat, or during any beat, makes the next cycle show beat 0 of the new burst.
- R10: If `start_i` and `term_i` are sampled high together, the new burst begins as in R2.
- R11: `term_i` while no burst is active has no effect: `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new burst with the fields below |
| start_col_i | input | COL_W (8) | Starting column address |
| len_code_i | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=full page, others=1 |
| wrap_il_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| term_i | input | 1 | End the current burst after the beat now shown |
| col_o | output | COL_W (8) | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The hardest case to reach is the full-page wrap. The column has to cross from 255 back to 0, which takes a long uninterrupted run. The stimulus therefore starts a page burst near the top of the page, with interleave requested, and follows it for more than 256 beats before terminating it. This checks both the wrap and the absence of `last_o`. The overlaps between controls are also placed on exact cycles: a start that coincides with a final beat, and a start issued together with terminate.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    case (code_i)
      BLEN_2:    mask_o = COL_W'(1);
      BLEN_4:    mask_o = COL_W'(3);
      BLEN_8:    mask_o = COL_W'(7);
      BLEN_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:   mask_o = '0;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_addr;
  logic [COL_W-1:0] il_addr;

  always_comb begin
    sum      = base_i + beat_i;
    seq_addr = (base_i & ~mask_i) | (sum & mask_i);
    il_addr  = base_i ^ (beat_i & mask_i);
    addr_o   = il_i ? il_addr : seq_addr;
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             wrap_il_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic             full_q, il_q;
  logic [COL_W-1:0] beat_nxt, addr_nxt;
  logic             stop_now;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  assign beat_nxt = beat_q + COL_W'(1);

  burst_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_q),
    .beat_i (beat_nxt),
    .mask_i (mask_q),
    .il_i   (il_q),
    .addr_o (addr_nxt)
  );

  assign stop_now = term_i || (last_o && !full_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      col_o   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      full_q  <= 1'b0;
      il_q    <= 1'b0;
    end else if (start_i) begin
      valid_o <= 1'b1;
      col_o   <= start_col_i;
      base_q  <= start_col_i;
      mask_q  <= dec_mask;
      beat_q  <= '0;
      full_q  <= dec_full;
      il_q    <= wrap_il_i && !dec_full;
      last_o  <= (dec_mask == '0) && !dec_full;
    end else if (valid_o) begin
      if (stop_now) begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end else begin
        beat_q <= beat_nxt;
        col_o  <= addr_nxt;
        last_o <= !full_q && (beat_nxt == mask_q);
      end
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  a_r2_start_gives_beat0: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r5_last_only_when_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  a_r5_after_last_idle: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  a_r7_page_start_no_last: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_code_i == 3'd7) |=> !last_o);

  a_r8_term_stops: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> !valid_o);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             wrap_il_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .wrap_il_i(wrap_il_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int blen(input logic [2:0] code);
    if (code < 3'd4) return 1 << code;
    if (code == 3'd7) return 256;
    return 1;
  endfunction

  function automatic int exp_col(input int base, input int k, input int n, input bit il);
    if (n == 256) return (base + k) % 256;
    if (il) return base ^ (k & (n - 1));
    return (base & ~(n - 1)) | ((base + k) & (n - 1));
  endfunction

  // Starts a burst and follows nbeats beats; terminates on beat term_at (-1: none).
  task automatic run_burst(input int base, input logic [2:0] code, input bit il,
                           input int nbeats, input int term_at, input string req);
    int n = blen(code);
    @(negedge clk);
    start_i = 1'b1; start_col_i = base[COL_W-1:0]; len_code_i = code; wrap_il_i = il;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < nbeats; k++) begin
      bit exp_last = (n != 256) && (k == n - 1);
      chk(valid_o === 1'b1, req, int'(valid_o), 1);
      chk(col_o === exp_col(base, k, n, il), req, int'(col_o), exp_col(base, k, n, il));
      chk(last_o === exp_last, req, int'(last_o), int'(exp_last));
      if (k == term_at) term_i = 1'b1;
      @(negedge clk);
    end
    term_i = 1'b0;
    chk(valid_o === 1'b0, req, int'(valid_o), 0);
    chk(last_o === 1'b0, req, int'(last_o), 0);
  endtask

  task automatic t_reset();
    chk(valid_o === 1'b0, "R1", int'(valid_o), 0);
    chk(last_o === 1'b0, "R1", int'(last_o), 0);
  endtask

  task automatic t_seq();
    run_burst(8'h2D, 3'd3, 1'b0, 8, -1, "R3");
    run_burst(8'hF6, 3'd2, 1'b0, 4, -1, "R3");
  endtask

  task automatic t_il();
    run_burst(8'h2D, 3'd3, 1'b1, 8, -1, "R4");
    run_burst(8'h47, 3'd2, 1'b1, 4, -1, "R4");
  endtask

  task automatic t_lengths();
    run_burst(8'h10, 3'd0, 1'b0, 1, -1, "R5");
    run_burst(8'h11, 3'd1, 1'b0, 2, -1, "R5");
    run_burst(8'h13, 3'd1, 1'b1, 2, -1, "R5");
  endtask

  task automatic t_bad_codes();
    for (int c = 4; c < 7; c++) run_burst(8'h5A + c, c[2:0], 1'b0, 1, -1, "R6");
  endtask

  task automatic t_page();
    run_burst(8'hFC, 3'd7, 1'b1, 300, 299, "R7");
  endtask

  task automatic t_term();
    run_burst(8'h30, 3'd3, 1'b0, 3, 2, "R8");
    run_burst(8'h80, 3'd0, 1'b1, 1, 0, "R8");
    repeat (3) begin
      @(negedge clk);
      chk(valid_o === 1'b0, "R8", int'(valid_o), 0);
    end
  endtask

  task automatic t_back2back();
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h21; len_code_i = 3'd1; wrap_il_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(last_o === 1'b1 && col_o === 8'h20, "R9", int'(col_o), 8'h20);
    start_i = 1'b1; start_col_i = 8'h66; len_code_i = 3'd2; wrap_il_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === 8'h66, "R9", int'(col_o), 8'h66);
    chk(last_o === 1'b0, "R9", int'(last_o), 0);
    @(negedge clk);
    chk(col_o === 8'h67, "R9", int'(col_o), 8'h67);
    start_i = 1'b1; start_col_i = 8'h90; len_code_i = 3'd0;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === 8'h90 && last_o === 1'b1, "R9", int'(col_o), 8'h90);
    @(negedge clk);
    chk(valid_o === 1'b0, "R9", int'(valid_o), 0);
  endtask

  task automatic t_start_term();
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'h40; len_code_i = 3'd3; wrap_il_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; term_i = 1'b1; start_col_i = 8'hA5; len_code_i = 3'd1;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === 8'hA5, "R10", int'(col_o), 8'hA5);
    @(negedge clk);
    chk(col_o === 8'hA4 && last_o === 1'b1, "R10", int'(col_o), 8'hA4);
    @(negedge clk);
    chk(valid_o === 1'b0, "R10", int'(valid_o), 0);
  endtask

  task automatic t_idle_term();
    @(negedge clk);
    term_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(valid_o === 1'b0, "R11", int'(valid_o), 0);
    end
    term_i = 1'b0;
    run_burst(8'h07, 3'd2, 1'b0, 4, -1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seq();
    t_il();
    t_lengths();
    t_bad_codes();
    t_page();
    t_term();
    t_back2back();
    t_start_term();
    t_idle_term();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule